// File: doc/BRIEF.md
# Strap-Sampled Suspend Indicator Pin Controller

This block drives one bidirectional board pin that does two jobs at different times. Right after reset the pin is left as an input. The level that a board resistor holds on it is read once, and that level picks between per-port power control and grouped power control. Much later the block turns the pin into an output. From then on the pin shows whether the device is running normally or is globally suspended.

The output polarity depends on the level that was read from the same pin. With the grouped choice the pin drives low while running and high while suspended. With the per-port choice it drives high while running and low while suspended. In both cases the driven level is the opposite of the resistor's idle level. The latched mode bit and a flag that marks it valid go to the rest of the chip. Both delays are parameters in clock cycles. At 12 MHz they are about 240 cycles (20 us) for the read and 600,000 cycles (50 ms) for the switch to output.

Top module: `strap_susp_pin`

## Requirements
- R1: While reset is held, and in the cycle after release, `pad_oe`, `pad_out`, `grp_mode` and `mode_ok` are all 0.
- R2: `mode_ok` stays 0 for the first STRAP_CYC-1 rising clock edges after reset release and is 1 after edge STRAP_CYC. `pad_oe` never rises before `mode_ok`.
- R3: When the pin level is held steady from reset through the read window, `grp_mode` becomes that level: 1 selects grouped mode and 0 selects per-port mode.
- R4: After `mode_ok` goes to 1, `grp_mode` and `mode_ok` keep their values until the next reset, whatever `pad_in` does.
- R5: `pad_oe` stays 0 for the first DRIVE_CYC-1 rising edges after reset release, is 1 after edge DRIVE_CYC, and then stays 1 until reset.
- R6: In grouped mode (`grp_mode`=1) with `pad_oe`=1, `pad_out` equals `sleep`: 0 while running and 1 while suspended. It follows `sleep` within the same cycle.
- R7: In per-port mode (`grp_mode`=0) with `pad_oe`=1, `pad_out` equals the inverse of `sleep`: 1 while running and 0 while suspended.
- R8: While `pad_oe` is 0, `pad_out` is 0 whatever the value of `sleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | 1 | Level read back from the pin |
| sleep | input | 1 | Global suspend status, 1 = suspended |
| pad_oe | output | 1 | Pin output enable |
| pad_out | output | 1 | Value driven on the pin when enabled |
| grp_mode | output | 1 | Latched mode: 1 grouped, 0 per-port |
| mode_ok | output | 1 | The mode bit has been latched |

## Verification
The bench checks the exact edge on which `mode_ok` and `pad_oe` rise, one edge on each side. A design with an off-by-one counter compare, or one that enables the driver early, would fail there. It toggles `pad_in` after the strap has been latched. A design that keeps re-reading the pin would then change mode in the middle of operation and flip the output polarity. It also toggles `sleep` at random in both modes, before and after the driver is enabled. These checks catch a swapped polarity, a missing inversion, and a pin that drives a value while it should still be an input.

// File: rtl/strap_susp_pin.sv
module strap_susp_pin #(
  parameter int STRAP_CYC = 240,
  parameter int DRIVE_CYC = 600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic sleep,
  output logic pad_oe,
  output logic pad_out,
  output logic grp_mode,
  output logic mode_ok
);
  localparam int CW = $clog2(DRIVE_CYC + 1);
  localparam logic [CW-1:0] STRAP_AT = CW'(STRAP_CYC - 1);
  localparam logic [CW-1:0] DRIVE_AT = CW'(DRIVE_CYC - 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(DRIVE_CYC);

  logic [CW-1:0] cnt;
  logic [1:0]    sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sync_q   <= 2'b00;
      grp_mode <= 1'b0;
      mode_ok  <= 1'b0;
      pad_oe   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pad_in};
      if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
      if (!mode_ok && cnt == STRAP_AT) begin
        grp_mode <= sync_q[1];
        mode_ok  <= 1'b1;
      end
      if (cnt == DRIVE_AT) pad_oe <= 1'b1;
    end
  end

  assign pad_out = pad_oe & (grp_mode ? sleep : ~sleep);

endmodule

module strap_susp_pin_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep,
  input logic pad_oe,
  input logic pad_out,
  input logic grp_mode,
  input logic mode_ok
);
  AST_OE_BEFORE_MODE: assert property (@(posedge clk) disable iff (!rst_n) pad_oe |-> mode_ok); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) mode_ok |=> (mode_ok && $stable(grp_mode))); // R4
  AST_NO_MODE_EARLY: assert property (@(posedge clk) disable iff (!rst_n) !mode_ok |-> !grp_mode); // R1
  AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) pad_oe |=> pad_oe); // R5
  AST_GRP_POLARITY: assert property (@(posedge clk) disable iff (!rst_n) (pad_oe && grp_mode) |-> (pad_out == sleep)); // R6
  AST_IND_POLARITY: assert property (@(posedge clk) disable iff (!rst_n) (pad_oe && !grp_mode) |-> (pad_out == !sleep)); // R7
  AST_QUIET_INPUT: assert property (@(posedge clk) disable iff (!rst_n) !pad_oe |-> !pad_out); // R8
endmodule

bind strap_susp_pin strap_susp_pin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .pad_oe(pad_oe),
  .pad_out(pad_out), .grp_mode(grp_mode), .mode_ok(mode_ok)
);

// File: tb/strap_susp_pin_tb.sv
`timescale 1ns/1ps
module strap_susp_pin_tb;
  localparam int S = 24;
  localparam int D = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pad_in = 1'b0;
  logic sleep = 1'b0;
  logic pad_oe, pad_out, grp_mode, mode_ok;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strap_susp_pin #(.STRAP_CYC(S), .DRIVE_CYC(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .sleep(sleep),
    .pad_oe(pad_oe), .pad_out(pad_out), .grp_mode(grp_mode), .mode_ok(mode_ok)
  );

  function automatic logic exp_out(input logic oe, input logic grp, input logic slp);
    if (!oe) return 1'b0;
    return grp ? slp : ~slp;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    pad_in = strap;
    sleep = $urandom_range(0, 1);
    repeat (3) @(negedge clk);
    check(pad_oe == 0 && pad_out == 0 && mode_ok == 0 && grp_mode == 0, "R1 reset state",
          {pad_oe, pad_out, mode_ok, grp_mode}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run(input logic strap, input bit wiggle);
    start(strap);
    for (int e = 1; e <= D + 60; e++) begin
      @(posedge clk);
      @(negedge clk);
      sleep = $urandom_range(0, 1);
      if (wiggle && e > S + 2) pad_in = $urandom_range(0, 1);
      #1;
      if (e == 1)
        check(pad_oe == 0 && mode_ok == 0, "R1 after release", {pad_oe, mode_ok}, 0);
      if (e == S - 1) check(mode_ok == 0, "R2 mode_ok early", mode_ok, 0);
      if (e == S) begin
        check(mode_ok == 1, "R2 mode_ok edge", mode_ok, 1);
        check(grp_mode == strap, "R3 strap latched", grp_mode, strap);
      end
      if (e > S) check(grp_mode == strap && mode_ok, "R4 mode held", grp_mode, strap);
      if (e == D - 1) check(pad_oe == 0, "R5 oe early", pad_oe, 0);
      if (e >= D) check(pad_oe == 1, "R5 oe on", pad_oe, 1);
      if (e < D) check(pad_out == 0, "R8 quiet while input", pad_out, 0);
      else if (strap)
        check(pad_out == exp_out(1'b1, 1'b1, sleep), "R6 grouped polarity", pad_out, exp_out(1'b1, 1'b1, sleep));
      else
        check(pad_out == exp_out(1'b1, 1'b0, sleep), "R7 per-port polarity", pad_out, exp_out(1'b1, 1'b0, sleep));
    end
  endtask

  initial begin
    void'($urandom(32'h5a17));
    run(1'b1, 1'b0);
    run(1'b0, 1'b0);
    run(1'b1, 1'b1);
    run(1'b0, 1'b1);
    for (int k = 0; k < 6; k++) run($urandom_range(0, 1), 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule